// File: doc/BRIEF.md
# Two-Wire Octal DAC Register Controller

This block is the slave side of a two-wire serial bus placed in front of a bank of DAC channels. It samples the clock and data lines with the system clock, recognises bus start and stop events and compares each incoming address against a fixed four-bit prefix joined to three strap pins. After a matching write address it acknowledges every byte and reads the stream that follows as command and data bytes in turn.

A command byte chooses a channel and carries a power-down request and a clear request. The data byte after it lands in that channel's staging register. Nothing reaches the channel outputs until the transfer ends with a stop event. At that point every staged value moves to its output register together, and the power-down and clear requests from the final command byte are applied. The outputs are the channel output registers, a power-down flag and an enable that pulls the data line low.

Top module: `dacbus_top`

## Requirements
- R1: After reset every channel output is 0x00, `powerDown` is 0 and `sdaPullLow` is 0.
- R2: An address byte whose upper seven bits equal 0101 followed by `addrPins[2:0]`, and whose bit 0 (direction) is 0, is acknowledged. `sdaPullLow` is high while SCL is high during the ninth clock pulse.
- R3: An address byte that does not match, or whose bit 0 is 1, is not acknowledged. The bytes that follow it up to the next start are neither acknowledged nor acted on, and the stop that ends such a transfer leaves all outputs unchanged.
- R4: A data byte following a command byte is written to the staging register of the channel given by command bits [2:0]. The channel outputs do not change before the stop event.
- R5: At a stop that ends an acknowledged transfer, every staging register is copied into its channel output register in the same clock cycle.
- R6: Command bit 3 is the power-down request. Each command byte replaces the pending value, and the value from the last command byte of the transfer is driven on `powerDown` at the stop (1 = powered down, 0 = normal).
- R7: A command byte that is the final byte before a stop writes no channel. Only its power-down and clear bits take effect.
- R8: Command bit 4 is the clear request. When it is 1 in the last command byte of a transfer, every staging register and every output register is 0x00 after the stop.
- R9: Command and data bytes in an acknowledged transfer are each acknowledged during their ninth clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrPins | input | 3 | Strap pins that form the low three address bits |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls the data line low |
| powerDown | output | 1 | Power-down state applied at the last stop |
| dacOut | output | CHANNELS*DATA_W | Channel output registers, channel 0 in the low bits |

## Verification
The bench uses the default parameters: eight channels of eight bits, two synchroniser stages and the 0101 prefix. With these values every value of the three-bit channel field selects a real channel, so a single transfer can stage all eight channels and the simultaneous copy at stop can be seen across the whole bank. The strap pins are tied to 101, and this makes both a matching address and a near-miss address available. The bench drives the bus at eight system clocks per quarter bit, which leaves room for the synchroniser and strobe latency before each sample.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

  localparam int BYTE_W      = 8;
  localparam int CMD_RST_BIT = 4;
  localparam int CMD_PD_BIT  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKGAP,
    ST_ACK
  } bus_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA,
    BK_NONE
  } byte_kind_t;

  typedef struct packed {
    logic              start;
    logic              cmdLoad;
    logic              dataLoad;
    logic              commit;
    logic [BYTE_W-1:0] rxByte;
  } ctl_strobe_t;

endpackage

// File: rtl/dacbus_ctrl.sv
module dacbus_ctrl
  import dacbus_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b0101
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  addrPins,
  output logic        sdaPullLow,
  output ctl_strobe_t strb
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;

  // two or more flops per line, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclPipe[SYNC_STAGES-1];
  assign sdaS      = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;

  bus_state_t        state;
  byte_kind_t        kind;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] rxNext;
  logic              ackGo;
  logic              transferOk;
  logic              addrHit;

  assign rxNext  = {shiftReg[BYTE_W-2:0], sdaS};
  assign addrHit = (rxNext[BYTE_W-1:1] == {ADDR_PREFIX, addrPins}) && !rxNext[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= BK_ADDR;
      bitCnt     <= '0;
      shiftReg   <= '0;
      ackGo      <= 1'b0;
      transferOk <= 1'b0;
      sdaPullLow <= 1'b0;
      strb       <= '0;
    end else begin
      strb <= '0;
      if (startCond) begin
        state      <= ST_RX;
        kind       <= BK_ADDR;
        bitCnt     <= '0;
        ackGo      <= 1'b0;
        transferOk <= 1'b0;
        sdaPullLow <= 1'b0;
        strb.start <= 1'b1;
      end else if (stopCond) begin
        state       <= ST_IDLE;
        bitCnt      <= '0;
        sdaPullLow  <= 1'b0;
        strb.commit <= transferOk;
        transferOk  <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              shiftReg <= rxNext;
              if (bitCnt == CNT_W'(BYTE_W-1)) begin
                bitCnt      <= '0;
                state       <= ST_ACKGAP;
                strb.rxByte <= rxNext;
                case (kind)
                  BK_ADDR: begin
                    ackGo      <= addrHit;
                    transferOk <= addrHit;
                    kind       <= BK_CMD;
                  end
                  BK_CMD: begin
                    ackGo        <= 1'b1;
                    strb.cmdLoad <= 1'b1;
                    kind         <= BK_DATA;
                  end
                  BK_DATA: begin
                    ackGo         <= 1'b1;
                    strb.dataLoad <= 1'b1;
                    kind          <= BK_CMD;
                  end
                  default: ackGo <= 1'b0;
                endcase
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          ST_ACKGAP: begin
            if (sclFall) begin
              if (ackGo) begin
                sdaPullLow <= 1'b1;
                state      <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              sdaPullLow <= 1'b0;
              state      <= ST_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dacbus_dp.sv
module dacbus_dp
  import dacbus_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_strobe_t                strb,
  output logic [CHANNELS*DATA_W-1:0] dacOut,
  output logic                       powerDown
);

  localparam int SEL_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  logic             pendPd;
  logic             pendRst;
  logic             cmdSeen;
  logic [SEL_W-1:0] pendSel;
  logic             clearAll;

  assign clearAll = strb.commit && cmdSeen && pendRst;

  // pending command state, last command byte wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPd    <= 1'b0;
      pendRst   <= 1'b0;
      cmdSeen   <= 1'b0;
      pendSel   <= '0;
      powerDown <= 1'b0;
    end else if (strb.start) begin
      cmdSeen <= 1'b0;
      pendRst <= 1'b0;
    end else if (strb.cmdLoad) begin
      pendPd  <= strb.rxByte[CMD_PD_BIT];
      pendRst <= strb.rxByte[CMD_RST_BIT];
      pendSel <= strb.rxByte[SEL_W-1:0];
      cmdSeen <= 1'b1;
    end else if (strb.commit) begin
      if (cmdSeen) powerDown <= pendPd;
      cmdSeen <= 1'b0;
      pendRst <= 1'b0;
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [DATA_W-1:0] inLatch;
    logic [DATA_W-1:0] outLatch;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inLatch  <= '0;
        outLatch <= '0;
      end else if (clearAll) begin
        inLatch  <= '0;
        outLatch <= '0;
      end else begin
        if (strb.commit) outLatch <= inLatch;
        if (strb.dataLoad && (pendSel == SEL_W'(c)))
          inLatch <= strb.rxByte[DATA_W-1:0];
      end
    end

    assign dacOut[c*DATA_W +: DATA_W] = outLatch;
  end

endmodule

// File: rtl/dacbus_top.sv
module dacbus_top
  import dacbus_pkg::*;
#(
  parameter int         CHANNELS    = 8,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b0101
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic [2:0]                 addrPins,
  output logic                       sdaPullLow,
  output logic                       powerDown,
  output logic [CHANNELS*DATA_W-1:0] dacOut
);

  ctl_strobe_t strb;
  logic        commitPulse;
  logic        cmdPulse;
  logic        dataPulse;

  assign commitPulse = strb.commit;
  assign cmdPulse    = strb.cmdLoad;
  assign dataPulse   = strb.dataLoad;

  dacbus_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_PREFIX(ADDR_PREFIX)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .addrPins  (addrPins),
    .sdaPullLow(sdaPullLow),
    .strb      (strb)
  );

  dacbus_dp #(
    .CHANNELS(CHANNELS),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dacOut   (dacOut),
    .powerDown(powerDown)
  );

endmodule

// File: rtl/dacbus_chk.sv
module dacbus_chk #(
  parameter int OUT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaPullLow,
  input logic             powerDown,
  input logic [OUT_W-1:0] dacOut,
  input logic             commitPulse,
  input logic             cmdPulse,
  input logic             dataPulse
);

  AST_OUT_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !commitPulse |=> $stable(dacOut)); // R5

  AST_PD_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !commitPulse |=> $stable(powerDown)); // R6

  AST_ACK_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn); // R2

  AST_ACK_RELEASE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commitPulse, cmdPulse, dataPulse})); // R4

endmodule

bind dacbus_top dacbus_chk #(.OUT_W(CHANNELS*DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaPullLow (sdaPullLow),
  .powerDown  (powerDown),
  .dacOut     (dacOut),
  .commitPulse(commitPulse),
  .cmdPulse   (cmdPulse),
  .dataPulse  (dataPulse)
);

// File: tb/sim_dacbus_top.sv
module sim_dacbus_top;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic [2:0]  pins = 3'b101;
  logic        sdaPullLow;
  logic        powerDown;
  logic [63:0] dacOut;
  logic        sdaLine;

  int checks = 0;
  int errors = 0;
  logic [7:0] expCh [8];
  logic       expPd;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #2 clk = ~clk;

  dacbus_top u0 (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclM),
    .sdaIn     (sdaLine),
    .addrPins  (pins),
    .sdaPullLow(sdaPullLow),
    .powerDown (powerDown),
    .dacOut    (dacOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expVec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = expCh[i];
    return v;
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ();
      sclM = 1'b1; waitQ(); waitQ();
      sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    acked = (sdaLine == 1'b0);
    waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic testReset();
    chk("R1 dacOut", dacOut, 64'h0);
    chk("R1 powerDown", {63'h0, powerDown}, 64'h0);
    chk("R1 sdaPullLow", {63'h0, sdaPullLow}, 64'h0);
  endtask

  task automatic testTwoChannels();
    logic a;
    busStart();
    sendByte(8'h5A, a); chk("R2 address ack", {63'h0, a}, 64'h1);
    sendByte(8'h02, a); chk("R9 command ack", {63'h0, a}, 64'h1);
    sendByte(8'h5A, a); chk("R9 data ack", {63'h0, a}, 64'h1);
    sendByte(8'h05, a);
    sendByte(8'hC3, a);
    chk("R4 outputs held before stop", dacOut, expVec());
    busStop();
    expCh[2] = 8'h5A; expCh[5] = 8'hC3;
    chk("R5 two channels after stop", dacOut, expVec());
  endtask

  task automatic testAllChannels();
    logic a;
    busStart();
    sendByte(8'h5A, a);
    for (int c = 0; c < 8; c++) begin
      sendByte(8'(c), a);
      sendByte(8'(8'h11 * (c + 1)), a);
    end
    chk("R4 all staged, outputs held", dacOut, expVec());
    busStop();
    for (int c = 0; c < 8; c++) expCh[c] = 8'(8'h11 * (c + 1));
    chk("R5 all channels together", dacOut, expVec());
  endtask

  task automatic testBadAddress();
    logic a;
    busStart();
    sendByte(8'h56, a); chk("R3 pin mismatch nack", {63'h0, a}, 64'h0);
    sendByte(8'h08, a); chk("R3 later byte nack", {63'h0, a}, 64'h0);
    sendByte(8'hEE, a);
    busStop();
    chk("R3 outputs unchanged", dacOut, expVec());
    chk("R3 powerDown unchanged", {63'h0, powerDown}, {63'h0, expPd});
    busStart();
    sendByte(8'h5B, a); chk("R3 read bit nack", {63'h0, a}, 64'h0);
    sendByte(8'h11, a);
    busStop();
    chk("R3 read attempt no effect", dacOut, expVec());
  endtask

  task automatic testPowerDown();
    logic a;
    busStart();
    sendByte(8'h5A, a);
    sendByte(8'h09, a);
    sendByte(8'h77, a);
    chk("R6 pd not applied before stop", {63'h0, powerDown}, 64'h0);
    busStop();
    expCh[1] = 8'h77; expPd = 1'b1;
    chk("R6 powered down", {63'h0, powerDown}, 64'h1);
    chk("R6 data still committed", dacOut, expVec());
    busStart();
    sendByte(8'h5A, a);
    sendByte(8'h03, a); chk("R7 trailing command ack", {63'h0, a}, 64'h1);
    busStop();
    expPd = 1'b0;
    chk("R6 resumed", {63'h0, powerDown}, 64'h0);
    chk("R7 trailing command writes no channel", dacOut, expVec());
    busStart();
    sendByte(8'h5A, a);
    sendByte(8'h0C, a);
    sendByte(8'h99, a);
    sendByte(8'h06, a);
    busStop();
    expCh[4] = 8'h99;
    chk("R6 last command pd wins", {63'h0, powerDown}, 64'h0);
    chk("R7 data before trailing cmd kept", dacOut, expVec());
  endtask

  task automatic testClear();
    logic a;
    busStart();
    sendByte(8'h5A, a);
    sendByte(8'h10, a);
    chk("R8 nothing cleared before stop", dacOut, expVec());
    busStop();
    for (int c = 0; c < 8; c++) expCh[c] = 8'h00;
    chk("R8 outputs cleared", dacOut, expVec());
    busStart();
    sendByte(8'h5A, a);
    sendByte(8'h06, a);
    sendByte(8'hA5, a);
    busStop();
    expCh[6] = 8'hA5;
    chk("R8 staging registers cleared", dacOut, expVec());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) expCh[c] = 8'h00;
    expPd = 1'b0;
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testTwoChannels();
    testAllChannels();
    testBadAddress();
    testPowerDown();
    testClear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule